// File: doc/BRIEF.md
# Priority Flow Control Pause Generator

This block decides when one full-duplex Ethernet port must ask its link partner to stop or resume sending traffic of particular priorities, and what that request contains. Eight congestion trigger inputs, one per priority, are qualified by a per-priority participation mask, a global receive flow control enable and a full-duplex flag. Whenever the qualified state of any priority differs from what was last told to the partner, the block builds a frame descriptor. The descriptor holds a priority enable vector and eight 16-bit pause times, plus the fixed destination address and opcode of a priority pause frame.

A priority that becomes congested is reported with pause time FFFFh. A priority that recovers is reported with pause time 0000h. Both kinds can share one frame. Priorities with nothing new to report keep their enable bit clear, so the partner leaves them as they are. A refresh counter per paused priority repeats the pause-on before the partner's timer runs out. Turning receive flow control off releases every paused priority with a single cancel frame.

Frames leave only at a transmit frame boundary. The descriptor is launched only while no normal frame is in progress, and it is then held until the transmitter acknowledges it. Any trigger changes that arrive while a frame waits are folded into the next frame. The block does not track whether the port is itself being paused by its partner, so that state has no effect on generation.

Top module: `pfc_pause_gen`

## Requirements
- R1: No frame is launched while `full_duplex` is low. Dropping `full_duplex` silently forgets every paused priority and its refresh count. After `full_duplex` returns, priorities that are still congested are sent again as pause-on.
- R2: A priority whose bit in `flow_pri_mask` is 0 never sets its enable bit because of its trigger.
- R3: When a qualified trigger rises, the next frame has that priority's enable bit set and its pause time at FFFFh.
- R4: When a reported pause is released, the next frame has that priority's enable bit set and pause time 0000h. A single frame may mix pause-on and pause-off priorities. Priorities with a clear enable bit always carry 0000h.
- R5: A frame is launched only in a cycle where `tx_busy` is low. `pause_valid` then rises at the next clock edge. Changes made while `tx_busy` is high or while a frame waits are merged into one later frame.
- R6: From the rise of `pause_valid` until the clock edge at which `pause_ack` is sampled high, `pause_valid` stays high and the enable vector and pause times stay constant.
- R7: Each priority sent as pause-on loads REFRESH (FF00h by default) into its counter. The counter drops by one on each `quanta_tick`. When it reaches zero while the priority is still congested, the pause-on is sent again with enable bit set and FFFFh.
- R8: Clearing `rx_flow_en` while priorities are paused sends one frame that sets the enable bit of every paused priority, with all pause times at 0000h.
- R9: `pause_da` is 48'h0180C2000001 and `pause_opcode` is 16'h0101, with the first byte on the wire in bits [47:40] and [15:8] respectively. The pause time of priority p sits in `pause_times[16p+15:16p]`, and the enable bit of priority p is `pause_pev[p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | Port is in full-duplex mode |
| rx_flow_en | input | 1 | Global receive flow control enable |
| flow_pri_mask | input | NPRI | Priorities taking part in pause generation |
| pri_trigger | input | NPRI | Per-priority congestion trigger |
| quanta_tick | input | 1 | One pulse per pause quantum (512 bit times) |
| tx_busy | input | 1 | A normal frame is being transmitted |
| pause_ack | input | 1 | Transmitter has taken the descriptor |
| pause_valid | output | 1 | Descriptor valid, send request |
| pause_pev | output | NPRI | Priority enable vector |
| pause_times | output | NPRI*TW | Packed per-priority pause times |
| pause_da | output | 48 | Destination multicast address |
| pause_opcode | output | 16 | Pause frame opcode |

## Verification
The bench first asserts a single trigger, then swaps one priority off and another on in the same cycle. This tells a correct mixed frame apart from one that drops either half. A trigger on a masked priority, and triggers raised while duplex is off, must produce no frame at all. Raising two triggers on separate cycles while the transmitter is busy must yield one merged frame, which distinguishes merging from queuing one frame per change. Holding the acknowledge low while another trigger arrives shows that the descriptor stays frozen and that the late change goes into a second frame. Stopping the quantum ticks one short of expiry, then giving the final tick, separates the exact refresh point from early or late refresh. Disabling flow control shows that every paused priority is released together.

// File: rtl/pfc_pause_gen.sv
module pfc_pause_gen #(
  parameter int NPRI = 8,
  parameter int TW = 16,
  parameter logic [15:0] REFRESH = 16'hFF00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_duplex,
  input  logic              rx_flow_en,
  input  logic [NPRI-1:0]   flow_pri_mask,
  input  logic [NPRI-1:0]   pri_trigger,
  input  logic              quanta_tick,
  input  logic              tx_busy,
  input  logic              pause_ack,
  output logic              pause_valid,
  output logic [NPRI-1:0]   pause_pev,
  output logic [NPRI*TW-1:0] pause_times,
  output logic [47:0]       pause_da,
  output logic [15:0]       pause_opcode
);
  localparam logic [TW-1:0] TMAX = {TW{1'b1}};
  localparam logic [TW-1:0] RLOAD = TW'(REFRESH);

  logic [NPRI-1:0] want, rep, due, sel;
  logic [TW-1:0]   cnt [NPRI];
  logic            launch;

  assign pause_da     = 48'h0180C2000001;
  assign pause_opcode = 16'h0101;
  assign want   = {NPRI{full_duplex & rx_flow_en}} & flow_pri_mask & pri_trigger;
  assign launch = full_duplex & ~tx_busy & ~pause_valid & (|sel);

  for (genvar p = 0; p < NPRI; p++) begin : g_pri
    assign due[p] = rep[p] & want[p] & (cnt[p] == '0);
    assign sel[p] = (want[p] ^ rep[p]) | due[p];

    always_ff @(posedge clk) begin
      if (!rst_n || !full_duplex) cnt[p] <= '0;
      else if (launch && sel[p]) cnt[p] <= want[p] ? RLOAD : '0;
      else if (quanta_tick && rep[p] && cnt[p] != '0) cnt[p] <= cnt[p] - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pause_times[p*TW +: TW] <= '0;
      else if (launch) pause_times[p*TW +: TW] <= (sel[p] & want[p]) ? TMAX : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !full_duplex) rep <= '0;
    else if (launch) rep <= (rep & ~sel) | (want & sel);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pause_valid <= 1'b0;
      pause_pev   <= '0;
    end else if (launch) begin
      pause_valid <= 1'b1;
      pause_pev   <= sel;
    end else if (pause_ack) begin
      pause_valid <= 1'b0;
    end
  end

  logic bad_code;
  always_comb begin
    bad_code = 1'b0;
    for (int p = 0; p < NPRI; p++) begin
      if (!pause_pev[p] && pause_times[p*TW +: TW] != '0) bad_code = 1'b1;
      if (pause_times[p*TW +: TW] != '0 && pause_times[p*TW +: TW] != TMAX) bad_code = 1'b1;
    end
  end

  AST_TIME_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid |-> !bad_code); // R4
  AST_HALF_DUPLEX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_valid) |-> $past(full_duplex)); // R1
  AST_LAUNCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_valid) |-> !$past(tx_busy)); // R5
  AST_DESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pause_valid && !pause_ack |=> pause_valid && $stable(pause_pev) && $stable(pause_times)); // R6
  AST_CANCEL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_valid) && !$past(rx_flow_en) |-> pause_times == '0); // R8
  AST_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_valid) |-> pause_pev != '0); // R4
endmodule

// File: tb/pfc_pause_gen_test.sv
module pfc_pause_gen_test;
  localparam int NPRI = 8;
  localparam int TW = 16;
  localparam int RF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic full_duplex = 1'b1, rx_flow_en = 1'b1, quanta_tick = 1'b0, tx_busy = 1'b0, pause_ack = 1'b0;
  logic [NPRI-1:0] flow_pri_mask = '1, pri_trigger = '0;
  logic pause_valid;
  logic [NPRI-1:0] pause_pev;
  logic [NPRI*TW-1:0] pause_times;
  logic [47:0] pause_da;
  logic [15:0] pause_opcode;

  int compared = 0, mismatched = 0, cycles = 0;
  bit hold_ack = 1'b0, done = 1'b0;
  logic [NPRI-1:0]    q_pev [$];
  logic [NPRI*TW-1:0] q_t [$];
  string              q_tag [$];

  always #5 clk = ~clk;

  pfc_pause_gen #(.NPRI(NPRI), .TW(TW), .REFRESH(16'(RF))) uut (.*);

  function automatic logic [NPRI*TW-1:0] mk(input logic [NPRI-1:0] pev, input logic [NPRI-1:0] on);
    logic [NPRI*TW-1:0] t = '0;
    for (int p = 0; p < NPRI; p++)
      if (pev[p] && on[p]) t[p*TW +: TW] = 16'hFFFF;
    return t;
  endfunction

  task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [NPRI-1:0] pev, input logic [NPRI-1:0] on);
    q_pev.push_back(pev);
    q_t.push_back(mk(pev, on));
    q_tag.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (q_pev.size() != 0 && w < 100) begin step(1); w++; end
    check({tag, " drained"}, 192'(q_pev.size()), 192'd0);
    step(3);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // monitor: pop expected frames and acknowledge
  always @(negedge clk) begin
    pause_ack <= 1'b0;
    if (rst_n && pause_valid && !hold_ack) begin
      if (q_pev.size() == 0) begin
        check("unexpected frame R1/R2/R5", 192'(pause_pev), 192'd0);
      end else begin
        string tag = q_tag.pop_front();
        check({tag, " pev"}, 192'(pause_pev), 192'(q_pev.pop_front()));
        check({tag, " times"}, 192'(pause_times), 192'(q_t.pop_front()));
      end
      pause_ack <= 1'b1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_up();
    end
  end

  initial begin
    logic [NPRI-1:0]    hp;
    logic [NPRI*TW-1:0] ht;
    step(3);
    check("reset valid", 192'(pause_valid), 192'd0);
    check("reset times", 192'(pause_times), 192'd0);
    check("R9 address", 192'(pause_da), 192'h0180C2000001);
    check("R9 opcode", 192'(pause_opcode), 192'h0101);
    rst_n = 1'b1; step(2);

    push("R3 single on", 8'h04, 8'h04);
    pri_trigger[2] = 1'b1; drain("R3");

    push("R4 mixed", 8'h24, 8'h20);
    pri_trigger[2] = 1'b0; pri_trigger[5] = 1'b1; drain("R4");

    flow_pri_mask[6] = 1'b0; pri_trigger[6] = 1'b1; step(10);
    check("R2 masked quiet", 192'(pause_valid), 192'd0);

    tx_busy = 1'b1; pri_trigger[0] = 1'b1; step(3); pri_trigger[1] = 1'b1; step(5);
    check("R5 busy holds", 192'(pause_valid), 192'd0);
    push("R5 merged", 8'h03, 8'h03);
    tx_busy = 1'b0; drain("R5");

    hold_ack = 1'b1; pri_trigger[3] = 1'b1; step(2);
    hp = pause_pev; ht = pause_times;
    check("R6 valid up", 192'(pause_valid), 192'd1);
    check("R6 first pev", 192'(hp), 192'h08);
    pri_trigger[4] = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1);
      check("R6 held pev", 192'(pause_pev), 192'(hp));
      check("R6 held times", 192'(pause_times), 192'(ht));
    end
    push("R6 held frame", 8'h08, 8'h08);
    push("R6 late change", 8'h10, 8'h10);
    hold_ack = 1'b0; drain("R6");

    for (int i = 0; i < RF - 1; i++) begin quanta_tick = 1'b1; step(1); quanta_tick = 1'b0; step(1); end
    step(5);
    check("R7 no early refresh", 192'(pause_valid), 192'd0);
    push("R7 refresh", 8'h3B, 8'h3B);
    quanta_tick = 1'b1; step(1); quanta_tick = 1'b0; drain("R7");

    push("R8 cancel", 8'h3B, 8'h00);
    rx_flow_en = 1'b0; drain("R8");
    pri_trigger = '0; step(5);

    full_duplex = 1'b0; rx_flow_en = 1'b1; pri_trigger[7] = 1'b1; step(10);
    check("R1 half duplex quiet", 192'(pause_valid), 192'd0);
    push("R1 duplex back", 8'h80, 8'h80);
    full_duplex = 1'b1; drain("R1a");
    full_duplex = 1'b0; step(5);
    push("R1 resend", 8'h80, 8'h80);
    full_duplex = 1'b1; drain("R1b");
    finish_up();
  end
endmodule